// File: doc/BRIEF.md
# Modulo-N Integer-Step Numerically Controlled Oscillator

This block produces a stream of sine and cosine samples from a phase counter that wraps at a modulus N chosen at run time, instead of at a power of two. The step added each cycle is a whole number with no fractional bits, so the phase never needs to be truncated before the table lookup. With N and the sample clock chosen so that `step = N * f_out / f_sample` is an integer, the output carries no truncation spurs. For example, N = 200 and step 6 at a 10 MHz sample clock give 300 kHz.

Two sample tables, each `N_MAX` entries deep, are loaded through a simple write port. The first N entries of the sine table hold one period. When N is a multiple of 4, the cosine is read from the sine table a quarter period ahead. Otherwise it is read from a separate cosine table that holds N points of one period.

A new modulus or step is taken up only in a cycle where the phase wraps. The phase then restarts at 0, so the phase can never reach the modulus. A configuration that cannot be used is rejected and raises an error flag. Making or retuning the sample clock is outside this block.

Top module: `modn_nco`

## Requirements
- R1: While reset is asserted and directly after it, `outValid`, `sinOut`, `cosOut` and `cfgErr` are 0 and no configuration is active. No valid sample appears before a legal configuration is seen with `enable` high.
- R2: A configuration is legal when 1 <= `modIn` <= N_MAX and `stepIn` < `modIn`. When none is active, the first rising edge with `enable` high and a legal configuration makes it active with phase 0. At the next edge `outValid` rises with the sample for phase 0.
- R3: With an active configuration and `enable` high, each edge outputs the samples for the current phase p, with `sinOut` = sine table[p], and moves the phase to p+step, less N when that sum is N or more. Sample k after activation therefore has phase (k*step) mod N.
- R4: With a fixed configuration, the `sinOut` sequence repeats exactly with period N/gcd(N, step) samples.
- R5: When N mod 4 = 0, `cosOut` = sine table[(p + N/4) mod N].
- R6: When N mod 4 != 0, `cosOut` = cosine table[p].
- R7: A legal configuration that differs from the active one is adopted only at an edge whose phase update wraps. The next sample then has phase 0 under the new values. Until that edge, the old sequence continues.
- R8: One cycle after an illegal configuration (N = 0, N > N_MAX, or step >= N) is presented, `cfgErr` is 1, and it is 0 one cycle after a legal one. An illegal configuration is never adopted.
- R9: With `enable` low, `outValid` is 0 at the next edge and the phase holds. Sampling resumes from the same phase.
- R10: An edge with `tblWrEn` high writes `tblData` at `tblAddr`. `tblSel` = 0 selects the sine table and 1 selects the cosine table. A sample read after the write returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advance phase and emit a sample this cycle |
| modIn | input | CFG_W | Requested modulus N |
| stepIn | input | CFG_W | Requested integer phase step |
| tblWrEn | input | 1 | Table write strobe |
| tblSel | input | 1 | Table select: 0 sine, 1 cosine |
| tblAddr | input | IDX_W | Table write address |
| tblData | input | SAMPLE_W | Table write data |
| sinOut | output | SAMPLE_W | Sine sample |
| cosOut | output | SAMPLE_W | Cosine sample |
| outValid | output | 1 | Samples on sinOut/cosOut are new |
| cfgErr | output | 1 | Requested configuration is illegal |

## Verification
The bench targets a phase sum that lands exactly on N. A design that compares with "greater than" would index entry N, outside the period. It changes the configuration in the middle of a period; a design that adopts it at once would lose its phase relation or run past the new modulus. It also drives moduli that are not multiples of 4, where a design that still used the quarter offset would put out a wrong cosine. Finally, it presents N above N_MAX and a step not below N, where a design that accepted them would read past the table or never settle.

// File: rtl/modn_nco_pkg.sv
package modn_nco_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic sampleEn;     // read the tables and register a new sample
    logic cosFromSine;  // cosine comes from the sine table (N multiple of 4)
  } ncoStrobe_t;

endpackage

// File: rtl/modn_nco_modadd.sv
// Modular adder: (addA + addB) mod modulus, assuming both addends < modulus.
module modn_nco_modadd #(
  parameter int W  = 12,
  parameter int OW = 10
) (
  input  logic [W-1:0]  addA,
  input  logic [W-1:0]  addB,
  input  logic [W-1:0]  modulus,
  output logic [OW-1:0] result
);

  logic [W:0] sumWide;
  logic       reachMod;

  always_comb begin
    sumWide  = {1'b0, addA} + {1'b0, addB};
    reachMod = (sumWide >= {1'b0, modulus});
    result   = reachMod ? OW'(sumWide - {1'b0, modulus}) : OW'(sumWide);
  end

endmodule

// File: rtl/modn_nco_ctrl.sv
// Control: configuration checking, wrap-aligned reconfiguration, phase counter.
module modn_nco_ctrl
  import modn_nco_pkg::*;
#(
  parameter int N_MAX = 1024,
  parameter int CFG_W = 12,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] modIn,
  input  logic [CFG_W-1:0] stepIn,
  output ncoStrobe_t       strobe,
  output logic [IDX_W-1:0] sinAddr,
  output logic [IDX_W-1:0] cosAddr,
  output logic             cfgErr
);

  logic             actValid;
  logic [CFG_W-1:0] actN;
  logic [CFG_W-1:0] actStep;
  logic [CFG_W-1:0] actQuarter;
  logic             actCosShared;
  logic [IDX_W-1:0] acc;

  logic             legalIn;
  logic             cfgDiffers;
  logic             wrapNow;
  logic             loadNow;
  logic [IDX_W-1:0] phaseNext;
  logic [IDX_W-1:0] cosIdx;

  modn_nco_modadd #(.W(CFG_W), .OW(IDX_W)) phaseAdd_i (
    .addA   (CFG_W'(acc)),
    .addB   (actStep),
    .modulus(actN),
    .result (phaseNext)
  );

  modn_nco_modadd #(.W(CFG_W), .OW(IDX_W)) quarterAdd_i (
    .addA   (CFG_W'(acc)),
    .addB   (actQuarter),
    .modulus(actN),
    .result (cosIdx)
  );

  always_comb begin
    legalIn    = (modIn != '0) && (modIn <= CFG_W'(N_MAX)) && (stepIn < modIn);
    cfgDiffers = (modIn != actN) || (stepIn != actStep);
    // step < N, so a wrapped result is always below the current phase
    wrapNow    = (phaseNext < acc);
    loadNow    = enable && legalIn && (!actValid || (wrapNow && cfgDiffers));

    strobe.sampleEn    = enable && actValid;
    strobe.cosFromSine = actCosShared;
    sinAddr            = acc;
    cosAddr            = actCosShared ? cosIdx : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actValid     <= 1'b0;
      actN         <= '0;
      actStep      <= '0;
      actQuarter   <= '0;
      actCosShared <= 1'b0;
      acc          <= '0;
      cfgErr       <= 1'b0;
    end else begin
      cfgErr <= !legalIn;
      if (loadNow) begin
        actValid     <= 1'b1;
        actN         <= modIn;
        actStep      <= stepIn;
        actQuarter   <= modIn >> 2;
        actCosShared <= (modIn[1:0] == 2'b00);
        acc          <= '0;
      end else if (enable && actValid) begin
        acc <= phaseNext;
      end
    end
  end

  // Phase stays below the active modulus
  assert_phase_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    actValid |-> (CFG_W'(acc) < actN));

  // Active configuration only changes at a wrap
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (actValid && !(enable && wrapNow)) |=> ($stable(actN) && $stable(actStep)));

  // Oversized modulus is flagged
  assert_bad_mod_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (modIn > CFG_W'(N_MAX)) |=> cfgErr);

  // Phase holds while disabled
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(acc));

endmodule

// File: rtl/modn_nco_dp.sv
// Datapath: sine and cosine tables, write port, registered sample outputs.
module modn_nco_dp
  import modn_nco_pkg::*;
#(
  parameter int N_MAX    = 1024,
  parameter int IDX_W    = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ncoStrobe_t          strobe,
  input  logic [IDX_W-1:0]    sinAddr,
  input  logic [IDX_W-1:0]    cosAddr,
  input  logic                tblWrEn,
  input  logic                tblSel,
  input  logic [IDX_W-1:0]    tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  output logic [SAMPLE_W-1:0] sinOut,
  output logic [SAMPLE_W-1:0] cosOut,
  output logic                outValid
);

  logic [SAMPLE_W-1:0] sinTbl [N_MAX];
  logic [SAMPLE_W-1:0] cosTbl [N_MAX];

  always_ff @(posedge clk) begin
    if (tblWrEn) begin
      if (tblSel) cosTbl[tblAddr] <= tblData;
      else        sinTbl[tblAddr] <= tblData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinOut   <= '0;
      cosOut   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.sampleEn;
      if (strobe.sampleEn) begin
        sinOut <= sinTbl[sinAddr];
        cosOut <= strobe.cosFromSine ? sinTbl[cosAddr] : cosTbl[cosAddr];
      end
    end
  end

  // No sample is flagged in a cycle after the control withheld it
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.sampleEn |=> !outValid);

endmodule

// File: rtl/modn_nco.sv
// Modulo-N integer-step oscillator top.
module modn_nco
  import modn_nco_pkg::*;
#(
  parameter int N_MAX    = 1024,
  parameter int SAMPLE_W = 16,
  parameter int CFG_W    = $clog2(N_MAX + 1) + 1,
  parameter int IDX_W    = $clog2(N_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [CFG_W-1:0]    modIn,
  input  logic [CFG_W-1:0]    stepIn,
  input  logic                tblWrEn,
  input  logic                tblSel,
  input  logic [IDX_W-1:0]    tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  output logic [SAMPLE_W-1:0] sinOut,
  output logic [SAMPLE_W-1:0] cosOut,
  output logic                outValid,
  output logic                cfgErr
);

  ncoStrobe_t       strobe;
  logic [IDX_W-1:0] sinAddr;
  logic [IDX_W-1:0] cosAddr;

  modn_nco_ctrl #(.N_MAX(N_MAX), .CFG_W(CFG_W), .IDX_W(IDX_W)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .modIn  (modIn),
    .stepIn (stepIn),
    .strobe (strobe),
    .sinAddr(sinAddr),
    .cosAddr(cosAddr),
    .cfgErr (cfgErr)
  );

  modn_nco_dp #(.N_MAX(N_MAX), .IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .sinAddr (sinAddr),
    .cosAddr (cosAddr),
    .tblWrEn (tblWrEn),
    .tblSel  (tblSel),
    .tblAddr (tblAddr),
    .tblData (tblData),
    .sinOut  (sinOut),
    .cosOut  (cosOut),
    .outValid(outValid)
  );

endmodule

// File: tb/modn_nco_tb_top.sv
`timescale 1ns/1ps
module modn_nco_tb_top;
  localparam int N_MAX = 1024;
  localparam int SW    = 16;
  localparam int CW    = 12;
  localparam int IW    = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [CW-1:0] modIn = '0;
  logic [CW-1:0] stepIn = '0;
  logic          tblWrEn = 1'b0;
  logic          tblSel = 1'b0;
  logic [IW-1:0] tblAddr = '0;
  logic [SW-1:0] tblData = '0;
  logic [SW-1:0] sinOut, cosOut;
  logic          outValid, cfgErr;

  always #2.5 clk = ~clk;

  modn_nco #(.N_MAX(N_MAX), .SAMPLE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .modIn(modIn), .stepIn(stepIn),
    .tblWrEn(tblWrEn), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .sinOut(sinOut), .cosOut(cosOut), .outValid(outValid), .cfgErr(cfgErr)
  );

  int checks = 0;
  int failures = 0;
  logic [SW-1:0] sinMem [N_MAX];
  logic [SW-1:0] cosMem [N_MAX];
  logic [SW-1:0] samp [400];
  int  sampCnt = 0;

  // expected-behaviour state, derived from the requirements
  bit  mValid = 0;
  int  mN = 0, mStep = 0, mAcc = 0;
  bit  mWrapLoad = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int  n, s, sum, cidx;
    bit  legal, expV;
    logic [SW-1:0] eSin, eCos;
    string sTag, cTag;
    @(posedge clk);
    @(negedge clk);
    n = int'(modIn);
    s = int'(stepIn);
    if (!rst_n) begin
      mValid = 0; mAcc = 0; mN = 0; mStep = 0; mWrapLoad = 0;
      check("R1 valid", outValid, 0);
      check("R1 sin", sinOut, 0);
      check("R1 cos", cosOut, 0);
      check("R1 err", cfgErr, 0);
    end else begin
      legal = (n >= 1) && (n <= N_MAX) && (s < n);
      expV  = enable && mValid;
      eSin  = '0; eCos = '0;
      sTag  = mWrapLoad ? "R7 sin" : "R3 sin";
      cTag  = "R6 cos";
      if (expV) begin
        eSin = sinMem[mAcc];
        if (mN % 4 == 0) begin
          cidx = (mAcc + mN / 4) % mN;
          eCos = sinMem[cidx];
          cTag = "R5 cos";
        end else begin
          eCos = cosMem[mAcc];
        end
      end
      check("R8 err", cfgErr, !legal);
      check(enable ? "R2 valid" : "R9 valid", outValid, expV);
      if (expV) begin
        check(sTag, sinOut, eSin);
        check(cTag, cosOut, eCos);
        if (sampCnt < 400) begin samp[sampCnt] = sinOut; sampCnt++; end
      end
      if (enable) begin
        if (!mValid) begin
          if (legal) begin mValid = 1; mN = n; mStep = s; mAcc = 0; end
          mWrapLoad = 0;
        end else begin
          mWrapLoad = 0;
          sum = mAcc + mStep;
          if (sum >= mN) begin
            if (legal && (n != mN || s != mStep)) begin
              mN = n; mStep = s; mAcc = 0; mWrapLoad = 1;
            end else begin
              mAcc = sum - mN;
            end
          end else begin
            mAcc = sum;
          end
        end
      end
    end
    if (tblWrEn) begin
      if (tblSel) cosMem[tblAddr] = tblData;
      else        sinMem[tblAddr] = tblData;
    end
  endtask

  task automatic doReset(int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) tick();
    rst_n = 1'b1;
  endtask

  task automatic setCfg(int n, int s);
    modIn  = CW'(n);
    stepIn = CW'(s);
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) tick();
  endtask

  task automatic printSummary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    printSummary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    doReset(3);

    // R1: enabled but illegal config gives no samples
    enable = 1'b1;
    setCfg(0, 0);
    run(3);
    enable = 1'b0;

    // R10: load both tables through the write port
    tblWrEn = 1'b1;
    for (int i = 0; i < N_MAX; i++) begin
      tblSel = 1'b0; tblAddr = IW'(i); tblData = SW'(i * 7 + 3); tick();
    end
    for (int i = 0; i < N_MAX; i++) begin
      tblSel = 1'b1; tblAddr = IW'(i); tblData = SW'((i * 13) ^ 16'h5a5a); tick();
    end
    tblWrEn = 1'b0;

    // R2/R3/R4/R5: N=200, step 6, period 100
    doReset(2);
    setCfg(200, 6);
    enable  = 1'b1;
    sampCnt = 0;
    tick();
    check("R2 first edge no sample", outValid, 0);
    run(320);
    check("R4 sample count", (sampCnt >= 300) ? 1 : 0, 1);
    for (int k = 0; k < 200; k++) check("R4 period 100", samp[k + 100], samp[k]);
    check("R4 not period 50", (samp[50] != samp[0]) ? 1 : 0, 1);
    check("R4 not period 20", (samp[20] != samp[0]) ? 1 : 0, 1);
    for (int k = 0; k < 100; k++) check("R3 phase k*step", samp[k], sinMem[(k * 6) % 200]);

    // R8: N above N_MAX and step >= N are rejected, sequence continues
    setCfg(2000, 2);
    run(20);
    setCfg(40, 40);
    run(20);

    // R7: legal change adopted only at a wrap
    setCfg(36, 5);
    run(80);
    // R6: modulus not multiple of 4, with sum landing exactly on N
    setCfg(30, 6);
    run(60);

    // R9: disable holds phase, resumes
    enable = 1'b0;
    run(5);
    enable = 1'b1;
    run(20);
    for (int i = 0; i < 6; i++) begin
      enable = i[0];
      tick();
    end
    enable = 1'b1;

    // R10: rewrite sine entry 0, then start at phase 0
    enable  = 1'b0;
    tblWrEn = 1'b1; tblSel = 1'b0; tblAddr = '0; tblData = 16'hbeef;
    tick();
    tblWrEn = 1'b0;
    doReset(2);
    setCfg(8, 1);
    enable = 1'b1;
    tick();
    tick();
    check("R10 new table value", sinOut, 16'hbeef);
    run(20);

    // N=1, step 0: constant output from cosine table entry 0
    doReset(2);
    setCfg(1, 0);
    run(10);
    check("R6 constant cos", cosOut, cosMem[0]);

    // Random legs
    for (int leg = 0; leg < 14; leg++) begin
      int n, s;
      doReset(2);
      n = int'($urandom_range(N_MAX, 1));
      if (leg % 3 == 0) n = int'($urandom_range(64, 1));
      s = (n > 1) ? int'($urandom_range(n - 1, 1)) : 0;
      setCfg(n, s);
      for (int c = 0; c < 400; c++) begin
        enable = ($urandom_range(9, 0) != 0);
        if ($urandom_range(59, 0) == 0) begin
          if ($urandom_range(3, 0) == 0) begin
            setCfg(int'($urandom_range(4095, 0)), int'($urandom_range(4095, 0)));
          end else begin
            n = int'($urandom_range(64, 1));
            s = (n > 1) ? int'($urandom_range(n - 1, 1)) : 0;
            setCfg(n, s);
          end
        end
        tick();
      end
    end

    printSummary();
    $finish;
  end

endmodule